// File: doc/BRIEF.md
# Per-CPU Interrupt Acknowledge Selector

This block sits in front of one processor and decides which interrupt that processor services next. It takes three inputs: a level-sensitive pending vector of external sources for this processor, one summary bit that says some inter-processor doorbell is waiting, and one summary bit that says some message-signalled doorbell is waiting. It turns them into one identifier. Software reads that identifier from an acknowledge register and keeps servicing until the value read is above 1022.

A second register, the cause register, shows the same pending state as a bitmap. A controller that is cascaded behind a parent interrupt line scans this bitmap instead of the identifier. Reads have no side effects. Every pending condition stays visible until it is cleared where it comes from.

The lowest identifier that is pending always wins. The two doorbell summaries hold identifiers 0 and 1, so they come before every external source. The priority encoder is either a linear scan or a balanced binary tree, selected by a parameter. Both variants return the same result.

Top module: `cpu_intack_sel`

## Requirements
- R1: A read of the acknowledge register (byte offset 0x44) with `rd_en_i` high returns the selected identifier in `rd_data_o[9:0]` with all higher bits zero. Data and `rd_valid_o` appear on the clock edge after the request.
- R2: When neither summary bit and no external source numbered 2 or above is pending, the acknowledge read returns 1023.
- R3: When the inter-processor doorbell summary is high, the acknowledge read returns 0, whatever else is pending.
- R4: When the message-signalled summary is high and the inter-processor summary is low, the acknowledge read returns 1.
- R5: With both summaries low, the acknowledge read returns the lowest source number k (k >= 2) whose `pend_i[k]` is high.
- R6: `pend_i[0]` and `pend_i[1]` are reserved and affect neither register's read data.
- R7: A read of the cause register (byte offset 0x10) returns a bitmap with bit 0 = message-signalled summary, bit 1 = inter-processor summary, bit k = `pend_i[k]` for 2 <= k < NUM_SRC, and all other bits zero.
- R8: Reads do not clear pending state. Back-to-back reads with unchanged inputs return the same value.
- R9: A read of any other offset returns zero with `rd_valid_o` high. In a cycle after no request, `rd_valid_o` is low and `rd_data_o` is zero.
- R10: After reset, `rd_valid_o` and `rd_data_o` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pend_i | input | NUM_SRC | Level pending vector, bit k = source k (bits 0 and 1 reserved) |
| ipi_sum_i | input | 1 | Some inter-processor doorbell is pending |
| msi_sum_i | input | 1 | Some message-signalled doorbell is pending |
| rd_en_i | input | 1 | Register read request |
| rd_addr_i | input | ADDR_W | Byte offset of the read |
| rd_data_o | output | DATA_W | Registered read data |
| rd_valid_o | output | 1 | Read data valid, one cycle after the request |

## Verification
The bench sweeps every combination of a 12-source pending vector and both summary bits. For each combination it reads both registers from a tree-encoded instance and from a linear-encoded instance. This covers the following failure modes:
- An encoder that favours the highest index, or that drops a tie, returns a larger identifier whenever two sources are pending together.
- A design that lets reserved vector bits 0 and 1 through returns 0 or 1 while both summaries are low.
- A wrong idle code shows up as something other than 1023 on the empty pattern.
- A read that clears state, or an unmapped offset that leaks data, shows as a mismatch on the repeated read or on the unused-offset read.

// File: rtl/intack_pkg.sv
package intack_pkg;
   localparam int ID_W         = 10;
   localparam int ID_NONE      = 1023;
   localparam int ID_IPI       = 0;
   localparam int ID_MSI       = 1;
   localparam int FIRST_EXT_ID = 2;
   localparam logic [7:0] OFFS_ACK   = 8'h44;
   localparam logic [7:0] OFFS_CAUSE = 8'h10;
endpackage

// File: rtl/intack_prio_enc.sv
module intack_prio_enc #(
   parameter int N        = 32,
   parameter bit USE_TREE = 1'b1,
   localparam int IW      = (N > 1) ? $clog2(N) : 1
) (
   input  logic [N-1:0]  req_i,
   output logic          found_o,
   output logic [IW-1:0] idx_o
);
   generate
      if (USE_TREE) begin : g_tree
         localparam int LVL = IW;
         localparam int P   = 1 << LVL;
         logic          v_t  [0:LVL][0:P-1];
         logic [IW-1:0] ix_t [0:LVL][0:P-1];

         for (genvar i = 0; i < P; i++) begin : g_leaf
            if (i < N) begin : g_real
               assign v_t[LVL][i]  = req_i[i];
            end else begin : g_pad
               assign v_t[LVL][i]  = 1'b0;
            end
            assign ix_t[LVL][i] = IW'(i);
         end

         for (genvar l = 0; l < LVL; l++) begin : g_lvl
            for (genvar j = 0; j < P; j++) begin : g_node
               if (j < (1 << l)) begin : g_used
                  assign v_t[l][j]  = v_t[l+1][2*j] | v_t[l+1][2*j+1];
                  assign ix_t[l][j] = v_t[l+1][2*j] ? ix_t[l+1][2*j]
                                                     : ix_t[l+1][2*j+1];
               end else begin : g_idle
                  assign v_t[l][j]  = 1'b0;
                  assign ix_t[l][j] = '0;
               end
            end
         end

         assign found_o = v_t[0][0];
         assign idx_o   = ix_t[0][0];
      end else begin : g_linear
         always_comb begin
            found_o = 1'b0;
            idx_o   = '0;
            for (int k = N - 1; k >= 0; k--) begin
               if (req_i[k]) begin
                  found_o = 1'b1;
                  idx_o   = IW'(k);
               end
            end
         end
      end
   endgenerate
endmodule

// File: rtl/intack_cause_pack.sv
module intack_cause_pack #(
   parameter int N      = 32,
   parameter int DATA_W = 32
) (
   input  logic [N-1:0]      pend_i,
   input  logic              ipi_sum_i,
   input  logic              msi_sum_i,
   output logic [DATA_W-1:0] cause_o
);
   assign cause_o[0] = msi_sum_i;
   assign cause_o[1] = ipi_sum_i;
   generate
      for (genvar k = 2; k < DATA_W; k++) begin : g_bit
         if (k < N) begin : g_src
            assign cause_o[k] = pend_i[k];
         end else begin : g_zero
            assign cause_o[k] = 1'b0;
         end
      end
   endgenerate
endmodule

// File: rtl/intack_readport.sv
module intack_readport
   import intack_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_en_i,
   input  logic [ADDR_W-1:0] rd_addr_i,
   input  logic [ID_W-1:0]   ack_id_i,
   input  logic [DATA_W-1:0] cause_i,
   output logic [DATA_W-1:0] rd_data_o,
   output logic              rd_valid_o
);
   logic [DATA_W-1:0] rd_next;

   always_comb begin
      rd_next = '0;
      if (rd_en_i) begin
         if (rd_addr_i == ADDR_W'(OFFS_ACK))
            rd_next = {{(DATA_W-ID_W){1'b0}}, ack_id_i};
         else if (rd_addr_i == ADDR_W'(OFFS_CAUSE))
            rd_next = cause_i;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_data_o  <= '0;
         rd_valid_o <= 1'b0;
      end else begin
         rd_data_o  <= rd_next;
         rd_valid_o <= rd_en_i;
      end
   end

   a_r1_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en_i |=> rd_valid_o);
   a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en_i |=> (!rd_valid_o && rd_data_o == '0));
   a_r9_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en_i && rd_addr_i != ADDR_W'(OFFS_ACK) && rd_addr_i != ADDR_W'(OFFS_CAUSE))
      |=> rd_data_o == '0);
endmodule

// File: rtl/cpu_intack_sel.sv
module cpu_intack_sel
   import intack_pkg::*;
#(
   parameter int NUM_SRC  = 32,
   parameter int ADDR_W   = 8,
   parameter int DATA_W   = 32,
   parameter bit USE_TREE = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] pend_i,
   input  logic               ipi_sum_i,
   input  logic               msi_sum_i,
   input  logic               rd_en_i,
   input  logic [ADDR_W-1:0]  rd_addr_i,
   output logic [DATA_W-1:0]  rd_data_o,
   output logic               rd_valid_o
);
   localparam int IW = $clog2(NUM_SRC);

   generate
      if (NUM_SRC < 3)            begin : g_chk_min  $error("NUM_SRC must be at least 3");       end
      if (NUM_SRC > ID_NONE)      begin : g_chk_max  $error("NUM_SRC must stay below idle id");  end
      if (NUM_SRC > DATA_W)       begin : g_chk_cw   $error("cause map must fit in DATA_W");     end
      if (DATA_W < ID_W)          begin : g_chk_dw   $error("DATA_W must hold an identifier");   end
      if (ADDR_W < 8)             begin : g_chk_aw   $error("ADDR_W must reach both offsets");   end
   endgenerate

   logic [NUM_SRC-1:0] req;
   logic               enc_found;
   logic [IW-1:0]      enc_idx;
   logic [ID_W-1:0]    ack_id;
   logic [DATA_W-1:0]  cause;
   logic               unused_reserved;

   assign unused_reserved = ^pend_i[1:0];
   assign req = {pend_i[NUM_SRC-1:2], msi_sum_i, ipi_sum_i};

   intack_prio_enc #(.N(NUM_SRC), .USE_TREE(USE_TREE)) u_enc (
      .req_i   (req),
      .found_o (enc_found),
      .idx_o   (enc_idx)
   );

   assign ack_id = enc_found ? ID_W'(enc_idx) : ID_W'(ID_NONE);

   logic [NUM_SRC-1:0] below_mask;
   assign below_mask = (NUM_SRC'(1) << enc_idx) - NUM_SRC'(1);

   a_r5_lowest_wins: assert property (@(posedge clk) disable iff (!rst_n)
      enc_found |-> (req[enc_idx] && (req & below_mask) == '0));

   intack_cause_pack #(.N(NUM_SRC), .DATA_W(DATA_W)) u_cause (
      .pend_i    (pend_i),
      .ipi_sum_i (ipi_sum_i),
      .msi_sum_i (msi_sum_i),
      .cause_o   (cause)
   );

   intack_readport #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rd (
      .clk        (clk),
      .rst_n      (rst_n),
      .rd_en_i    (rd_en_i),
      .rd_addr_i  (rd_addr_i),
      .ack_id_i   (ack_id),
      .cause_i    (cause),
      .rd_data_o  (rd_data_o),
      .rd_valid_o (rd_valid_o)
   );

   a_r3_ipi_first: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en_i && rd_addr_i == ADDR_W'(OFFS_ACK) && ipi_sum_i) |=> rd_data_o == '0);
   a_r2_idle_code: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en_i && rd_addr_i == ADDR_W'(OFFS_ACK) && !ipi_sum_i && !msi_sum_i
       && pend_i[NUM_SRC-1:2] == '0) |=> rd_data_o == DATA_W'(ID_NONE));
   a_r7_cause_summary: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en_i && rd_addr_i == ADDR_W'(OFFS_CAUSE))
      |=> (rd_data_o[0] == $past(msi_sum_i) && rd_data_o[1] == $past(ipi_sum_i)));
   a_r1_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en_i && rd_addr_i == ADDR_W'(OFFS_ACK)) |=> rd_data_o[DATA_W-1:ID_W] == '0);
endmodule

// File: tb/tb_cpu_intack_sel.sv
`timescale 1ns/1ps
module tb_cpu_intack_sel;
   localparam int N  = 12;
   localparam int AW = 8;
   localparam int DW = 32;
   localparam logic [AW-1:0] A_ACK   = 8'h44;
   localparam logic [AW-1:0] A_CAUSE = 8'h10;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [N-1:0]  pend = '0;
   logic          ipi = 1'b0;
   logic          msi = 1'b0;
   logic          rd_en = 1'b0;
   logic [AW-1:0] rd_addr = '0;
   logic [DW-1:0] data_t, data_l;
   logic          valid_t, valid_l;

   int checks = 0;
   int fails  = 0;
   int cycles = 0;
   bit done   = 1'b0;

   always #2 clk = ~clk;

   cpu_intack_sel #(.NUM_SRC(N), .ADDR_W(AW), .DATA_W(DW), .USE_TREE(1'b1)) dut (
      .clk(clk), .rst_n(rst_n), .pend_i(pend), .ipi_sum_i(ipi), .msi_sum_i(msi),
      .rd_en_i(rd_en), .rd_addr_i(rd_addr), .rd_data_o(data_t), .rd_valid_o(valid_t));

   cpu_intack_sel #(.NUM_SRC(N), .ADDR_W(AW), .DATA_W(DW), .USE_TREE(1'b0)) dut_lin (
      .clk(clk), .rst_n(rst_n), .pend_i(pend), .ipi_sum_i(ipi), .msi_sum_i(msi),
      .rd_en_i(rd_en), .rd_addr_i(rd_addr), .rd_data_o(data_l), .rd_valid_o(valid_l));

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (cycles > 190000 && !done) begin
         fails = fails + 1;
         $display("FAIL watchdog (all requirements) actual=timeout expected=finish");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   function automatic logic [DW-1:0] exp_ack(logic [N-1:0] p, logic i, logic m);
      if (i) return 0;
      if (m) return 1;
      for (int k = 2; k < N; k++) if (p[k]) return DW'(k);
      return 1023;
   endfunction

   function automatic logic [DW-1:0] exp_cause(logic [N-1:0] p, logic i, logic m);
      logic [DW-1:0] c = '0;
      c[0] = m;
      c[1] = i;
      for (int k = 2; k < N; k++) c[k] = p[k];
      return c;
   endfunction

   task automatic check(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
      checks = checks + 1;
      if (act !== exp) begin
         fails = fails + 1;
         $display("FAIL %s actual=%0h expected=%0h pend=%b ipi=%b msi=%b",
                  req, act, exp, pend, ipi, msi);
      end
   endtask

   task automatic do_read(logic [AW-1:0] a);
      @(negedge clk);
      rd_en   = 1'b1;
      rd_addr = a;
      @(negedge clk);
      rd_en   = 1'b0;
   endtask

   initial begin
      repeat (2) @(negedge clk);
      check("R10 reset data", data_t, '0);
      check("R10 reset valid", {31'b0, valid_t}, '0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R9 idle valid", {31'b0, valid_t | valid_l}, '0);

      for (int p = 0; p < (1 << (N + 2)); p++) begin
         logic [DW-1:0] ea, ec;
         string tag;
         @(negedge clk);
         pend = p[N-1:0];
         ipi  = p[N];
         msi  = p[N+1];
         ea = exp_ack(pend, ipi, msi);
         ec = exp_cause(pend, ipi, msi);
         if (ipi)                 tag = "R3 ipi wins";
         else if (msi)            tag = "R4 msi next";
         else if (ea == 1023)     tag = "R2 idle code";
         else                     tag = "R5 lowest source";
         do_read(A_ACK);
         check(tag, data_t, ea);
         check({tag, " linear"}, data_l, ea);
         if (pend[1:0] != 2'b00 && !ipi && !msi)
            check("R6 reserved bits ignored", data_t, ea);
         if (p % 64 == 0)
            check("R1 valid and upper bits", {31'b0, valid_t}, 32'd1);
         do_read(A_CAUSE);
         check("R7 cause bitmap", data_t, ec);
         if (p % 97 == 0) check("R7 cause bitmap linear", data_l, ec);
         if (p % 257 == 0) begin
            do_read(A_ACK);
            check("R8 reread ack unchanged", data_t, ea);
            do_read(8'h20);
            check("R9 unmapped offset zero", data_t, '0);
            check("R9 unmapped valid", {31'b0, valid_t}, 32'd1);
            @(negedge clk);
            check("R9 idle data zero", data_t, '0);
         end
      end

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule